// File: doc/BRIEF.md
# Lock-Gated Serial Word Shifter

This block sends one fixed-width word per word period over a single serial line, least significant bit first. A one-cycle bit strobe (`bit_en`) sets the pace, one pulse per bit. A word period therefore spans `WORD_W` strobes. The default is 20, so the bit rate is twenty times the word rate.

The line has three conditions, and they follow the power-enable input:
- **Off:** while power is held down, or while the input supply is reported missing, the output is high impedance.
- **Settling:** when power is released, the block counts a fixed number of word periods (`LOCK_WORDS`, 17,100 by default). During this count the line is held at a zero differential level and is not driven.
- **Active:** after the count, the block shifts data.

A two-bit frequency-range selection is captured at power-up and reported as a status code.

A new word is taken only at a word boundary, so a word already started is always finished. The surrounding logic keeps `word_in` valid on the strobe that ends each word. The other pins of a line driver (high-impedance control, idle level) follow `drive_en` and `idle_zero`.

Top module: `lock_gated_serializer`

## Requirements
- R1: After reset the block is off: `drive_en`, `idle_zero` and `ser_out` are 0 and `range_code` is 2'b00.
- R2: On the clock after `pwr_on` is low or `supply_ok` is low, from any condition, the block is off (`drive_en`=0, `idle_zero`=0, `ser_out`=0), and any partial settling count is discarded.
- R3: On the clock after power is enabled (`pwr_on`=1 and `supply_ok`=1) from off, `idle_zero` is 1, `drive_en` is 0 and `ser_out` is 0.
- R4: Settling lasts exactly `LOCK_WORDS`×`WORD_W` `bit_en` pulses. On the clock of the last pulse `drive_en` rises, `idle_zero` falls, and `word_in` is loaded.
- R5: While active, after k `bit_en` pulses since a word was loaded, `ser_out` equals bit k of that word (bit 0 first).
- R6: The next word is sampled from `word_in` only on the clock of the `WORD_W`-th pulse of the current word. Changes of `word_in` at any other time do not affect `ser_out`.
- R7: Clocks without `bit_en` leave `ser_out` unchanged while active.
- R8: `range_code` takes the value of `range_sel` on the clock that leaves off, and ignores `range_sel` at all other times.
- R9: `drive_en` and `idle_zero` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_on | input | 1 | Power enable; low holds the block off |
| supply_ok | input | 1 | Input supply present; low forces off |
| bit_en | input | 1 | One-cycle strobe per serial bit |
| word_in | input | WORD_W | Next word to send |
| range_sel | input | 2 | Frequency-range selection (00 lowest to 11 highest) |
| ser_out | output | 1 | Serial data, LSB first, 0 unless active |
| drive_en | output | 1 | 1 when the line is driven; 0 means high impedance |
| idle_zero | output | 1 | 1 while settling: line held at zero differential |
| range_code | output | 2 | Range captured at power-up |

## Verification
The assertions take for granted that `bit_en` and `pwr_on` are synchronous to `clk`. They also assume the settling limit is at least one word period, so the counter bound and the off-to-settling-to-active order are meaningful. The stimulus changes every input one time unit after a rising edge. It sends strobes both back to back and with gaps of one and two idle clocks. It alters `word_in` mid-word only to confirm it is ignored. A short `LOCK_WORDS` is used so that full settling windows, including one restarted after a supply drop, fit in the run.

// File: rtl/lock_gated_serializer.sv
module lock_gated_serializer #(
  parameter int WORD_W     = 20,
  parameter int LOCK_WORDS = 17100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              supply_ok,
  input  logic              bit_en,
  input  logic [WORD_W-1:0] word_in,
  input  logic [1:0]        range_sel,
  output logic              ser_out,
  output logic              drive_en,
  output logic              idle_zero,
  output logic [1:0]        range_code
);
  localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int LCK_W = $clog2(LOCK_WORDS + 1);

  typedef enum logic [1:0] {ST_OFF, ST_LOCK, ST_RUN} st_t;

  st_t               st;
  logic [IDX_W-1:0]  idx;
  logic [LCK_W-1:0]  lcnt;
  logic [WORD_W-1:0] shreg;

  wire pd_ok     = pwr_on & supply_ok;
  wire last_bit  = bit_en && (idx == IDX_W'(WORD_W - 1));
  wire lock_done = last_bit && (lcnt == LCK_W'(LOCK_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_OFF;
      idx        <= '0;
      lcnt       <= '0;
      shreg      <= '0;
      range_code <= 2'b00;
    end else if (!pd_ok) begin
      st    <= ST_OFF;
      idx   <= '0;
      lcnt  <= '0;
      shreg <= '0;
    end else begin
      if (st != ST_OFF && bit_en)
        idx <= last_bit ? '0 : idx + 1'b1;
      case (st)
        ST_OFF: begin
          st         <= ST_LOCK;
          range_code <= range_sel;
        end
        ST_LOCK: if (last_bit) begin
          if (lock_done) begin
            st    <= ST_RUN;
            shreg <= word_in;
            lcnt  <= '0;
          end else begin
            lcnt <= lcnt + 1'b1;
          end
        end
        ST_RUN: if (bit_en)
          shreg <= last_bit ? word_in : (shreg >> 1);
        default: st <= ST_OFF;
      endcase
    end
  end

  assign drive_en  = (st == ST_RUN);
  assign idle_zero = (st == ST_LOCK);
  assign ser_out   = drive_en & shreg[0];

  // R2
  off_when_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_ok |=> (!drive_en && !idle_zero && !ser_out));

  // R3
  lock_after_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_ok && !drive_en && !idle_zero) |=> idle_zero);

  // R4
  run_from_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> $past(idle_zero) && $past(bit_en));

  // R4
  lock_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcnt < LCK_W'(LOCK_WORDS));

  // R7
  hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && !bit_en && pd_ok) |=> $stable(ser_out));

  // R8
  range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en || idle_zero) |=> $stable(range_code));

  // R9
  excl_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_en && idle_zero));
endmodule

// File: tb/lock_gated_serializer_bench.sv
module lock_gated_serializer_bench;
  localparam int W  = 20;
  localparam int LW = 3;

  logic clk = 1'b0, rst_n = 1'b0, pwr_on = 1'b0, supply_ok = 1'b1, bit_en = 1'b0;
  logic [W-1:0] word_in = '0;
  logic [1:0] range_sel = 2'b00;
  logic ser_out, drive_en, idle_zero;
  logic [1:0] range_code;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [W-1:0] VEC [8] = '{20'hA5A5A, 20'h00001, 20'h80000, 20'hFFFFF,
                                       20'h00000, 20'h55555, 20'h12345, 20'hF0F0F};

  always #4 clk = ~clk;

  lock_gated_serializer #(.WORD_W(W), .LOCK_WORDS(LW)) u_lock_gated_serializer (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .supply_ok(supply_ok), .bit_en(bit_en),
    .word_in(word_in), .range_sel(range_sel), .ser_out(ser_out), .drive_en(drive_en),
    .idle_zero(idle_zero), .range_code(range_code));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic en);
    bit_en = en;
    @(posedge clk);
    #1;
    bit_en = 1'b0;
  endtask

  task automatic status(input string req, input logic d, input logic z, input logic s);
    check(req, {29'd0, d, z, s}, {29'd0, d, z, s} & 32'd0 | {29'd0, drive_en, idle_zero, ser_out});
  endtask

  task automatic expect_state(input string req, input logic d, input logic z, input logic s);
    check(req, {29'd0, drive_en, idle_zero, ser_out}, {29'd0, d, z, s});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #3;
    // R1 reset state
    expect_state("R1", 1'b0, 1'b0, 1'b0);
    check("R1", {30'd0, range_code}, 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    tick(0);
    expect_state("R2", 1'b0, 1'b0, 1'b0);

    // R3 release power, R8 capture range
    range_sel = 2'b11;
    pwr_on = 1'b1;
    word_in = VEC[0];
    tick(0);
    expect_state("R3", 1'b0, 1'b1, 1'b0);
    check("R8", {30'd0, range_code}, 32'd3);

    // R4 settling window length
    for (int i = 0; i < LW*W - 1; i++) tick(1);
    expect_state("R4", 1'b0, 1'b1, 1'b0);
    tick(1);
    expect_state("R4", 1'b1, 1'b0, VEC[0][0]);

    // R5 R6 R7 vector walk
    for (int v = 0; v < 8; v++) begin
      for (int b = 0; b < W; b++) begin
        check("R5", {31'd0, ser_out}, {31'd0, VEC[v][b]});
        if (b == 7) begin
          word_in = ~VEC[(v+1)%8];
          for (int g = 0; g < v % 3; g++) begin
            tick(0);
            check("R7", {31'd0, ser_out}, {31'd0, VEC[v][b]});
          end
        end
        if (b == W-1) word_in = VEC[(v+1)%8];
        if (b == 12) word_in = 20'h3C3C3;
        if (b == 13) word_in = VEC[(v+1)%8] ^ 20'h00001;
        tick(1);
        if (b == 13) word_in = VEC[(v+1)%8];
      end
    end
    // R6 first word repeats after wrap
    check("R6", {31'd0, ser_out}, {31'd0, VEC[0][0]});

    // R8 range ignored while active
    range_sel = 2'b01;
    tick(1);
    check("R8", {30'd0, range_code}, 32'd3);

    // R2 power-down mid-word
    pwr_on = 1'b0;
    tick(1);
    expect_state("R2", 1'b0, 1'b0, 1'b0);

    // R2 supply loss discards partial settling
    range_sel = 2'b10;
    pwr_on = 1'b1;
    tick(0);
    expect_state("R3", 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 30; i++) tick(1);
    supply_ok = 1'b0;
    tick(1);
    expect_state("R2", 1'b0, 1'b0, 1'b0);
    supply_ok = 1'b1;
    word_in = 20'h00003;
    tick(0);
    check("R8", {30'd0, range_code}, 32'd2);
    for (int i = 0; i < LW*W - 1; i++) tick(1);
    expect_state("R2", 1'b0, 1'b1, 1'b0);
    tick(1);
    expect_state("R4", 1'b1, 1'b0, 1'b1);
    tick(0);
    check("R7", {31'd0, ser_out}, 32'd1);
    tick(1);
    check("R5", {31'd0, ser_out}, 32'd1);
    tick(1);
    check("R5", {31'd0, ser_out}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule